// File: doc/BRIEF.md
# Read-Modify-Write Operation Unit

This unit performs one read-modify-write step on a single full-width word in memory. A sequencer upstream presents a 4-bit method code, a target address, a mask word and a value word, then pulses `start`. The unit reads the addressed word over a simple request/grant memory port. It transforms the word with the selected method and writes the result back to the same address. It then pulses `done` for one cycle, with `error` valid in that same cycle.

The method code sits in bits 11:8 of the descriptor control word. The upstream sequencer extracts that field and drives it on `op_method`. The other bits of the control word (interrupt, stop and so on) belong to the sequencer and never reach this unit. Only full-word accesses are made.

The memory port is request based. `mem_req` stays high, with address, direction and write data held, until `mem_gnt` is seen. A read is answered later by `mem_rvalid` together with `mem_rdata`. The error flag `mem_err` is meaningful together with `mem_rvalid` for a read and together with `mem_gnt` for a write.

Top module: `rmw_op_unit`

## Requirements
- R1: After synchronous reset, `done`, `error` and `mem_req` are all 0.
- R2: Method 0 writes `(read & ~mask) | value`.
- R3: Method 1 writes read+1 and method 2 writes read-1, both modulo 2^32 (0xFFFFFFFF+1 gives 0, 0-1 gives 0xFFFFFFFF).
- R4: Method 3 writes read shifted right by one and method 4 writes read shifted left by one, both logical with zero fill.
- R5: Method 5 rotates right by one, so bit 0 becomes bit 31. Method 6 rotates left by one, so bit 31 becomes bit 0.
- R6: Method 7 writes `~read`. Methods 8, 9 and 10 write read XOR mask, read OR mask and read AND mask.
- R7: Method codes 11 to 15 cause no memory request. `done` and `error` are both 1 in the cycle right after the clock edge that accepted `start`.
- R8: A valid operation issues exactly one read, then exactly one write to the same address. Each request is held stable until it is granted. `done` is high for exactly one cycle, in the cycle after the write grant, with `error` 0.
- R9: `mem_err` returned with the read data aborts the operation with no write, and `done` is raised with `error` 1.
- R10: `mem_err` returned with the write grant ends the operation with `done` and `error` both 1.
- R11: `start` is ignored unless the unit is idle, including in the cycle in which `done` is high. An ignored start issues no memory request and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_method | input | 4 | Method code, descriptor bits 11:8 |
| op_addr | input | AW | Target word address |
| op_mask | input | DW | Mask operand |
| op_value | input | DW | Value operand |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| mem_err | input | 1 | Error flag for the read response or the write grant |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Operation failed (valid with done) |

## Verification
Two things can fall in the same cycle: a new `start` and the unit's own completion cycle, when `done` is high. A new `start` can also land in any busy cycle. The bench provokes the first case by raising `start` exactly in the cycle where it sees `done`. It provokes the second by holding `start` high for the whole of an increment operation. The results are judged at the memory model. The word must change exactly once, the write count must go up by one at most, and no request may appear after the pulse. Random grant and read latencies, including a grant in the first request cycle, also make the write grant and the error flag coincide with the end of each state.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int METHOD_W    = 4;
    localparam int METHOD_LSB  = 8;
    localparam int NUM_METHODS = 11;

    typedef enum logic [METHOD_W-1:0] {
        M_MERGE = 4'd0,
        M_INC   = 4'd1,
        M_DEC   = 4'd2,
        M_SHR   = 4'd3,
        M_SHL   = 4'd4,
        M_ROR   = 4'd5,
        M_ROL   = 4'd6,
        M_INV   = 4'd7,
        M_XOR   = 4'd8,
        M_OR    = 4'd9,
        M_AND   = 4'd10
    } rmw_method_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WAIT_RDATA,
        S_WRITE,
        S_DONE
    } rmw_state_e;

    function automatic logic method_reserved(input logic [METHOD_W-1:0] m);
        return m >= METHOD_W'(NUM_METHODS);
    endfunction

endpackage

// File: rtl/rmw_xform.sv
module rmw_xform
    import rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [METHOD_W-1:0] method,
    input  logic [DW-1:0]       rd_word,
    input  logic [DW-1:0]       mask_word,
    input  logic [DW-1:0]       val_word,
    output logic [DW-1:0]       new_word
);

    always_comb begin
        unique case (rmw_method_e'(method))
            M_MERGE: new_word = (rd_word & ~mask_word) | val_word;
            M_INC:   new_word = rd_word + DW'(1);
            M_DEC:   new_word = rd_word - DW'(1);
            M_SHR:   new_word = rd_word >> 1;
            M_SHL:   new_word = rd_word << 1;
            M_ROR:   new_word = {rd_word[0], rd_word[DW-1:1]};
            M_ROL:   new_word = {rd_word[DW-2:0], rd_word[DW-1]};
            M_INV:   new_word = ~rd_word;
            M_XOR:   new_word = rd_word ^ mask_word;
            M_OR:    new_word = rd_word | mask_word;
            M_AND:   new_word = rd_word & mask_word;
            default: new_word = rd_word;
        endcase
    end

endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [METHOD_W-1:0] op_method,
    input  logic [AW-1:0]       op_addr,
    input  logic [DW-1:0]       op_mask,
    input  logic [DW-1:0]       op_value,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic                mem_err,
    input  logic [DW-1:0]       xf_word,
    output logic [METHOD_W-1:0] method_q,
    output logic [DW-1:0]       mask_q,
    output logic [DW-1:0]       value_q,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic                done,
    output logic                error,
    output rmw_state_e          state
);

    rmw_state_e    state_q;
    logic          err_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            err_q    <= 1'b0;
            method_q <= '0;
            addr_q   <= '0;
            mask_q   <= '0;
            value_q  <= '0;
            wdata_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        method_q <= op_method;
                        addr_q   <= op_addr;
                        mask_q   <= op_mask;
                        value_q  <= op_value;
                        if (method_reserved(op_method)) begin
                            err_q   <= 1'b1;
                            state_q <= S_DONE;
                        end else begin
                            err_q   <= 1'b0;
                            state_q <= S_READ;
                        end
                    end
                end
                S_READ: begin
                    if (mem_gnt) state_q <= S_WAIT_RDATA;
                end
                S_WAIT_RDATA: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            err_q   <= 1'b1;
                            state_q <= S_DONE;
                        end else begin
                            wdata_q <= xf_word;
                            state_q <= S_WRITE;
                        end
                    end
                end
                S_WRITE: begin
                    if (mem_gnt) begin
                        err_q   <= mem_err;
                        state_q <= S_DONE;
                    end
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state_q == S_READ) || (state_q == S_WRITE);
        mem_we    = (state_q == S_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        done      = (state_q == S_DONE);
        error     = (state_q == S_DONE) && err_q;
        state     = state_q;
    end

endmodule

// File: rtl/rmw_op_unit.sv
module rmw_op_unit
    import rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [METHOD_W-1:0] op_method,
    input  logic [AW-1:0]       op_addr,
    input  logic [DW-1:0]       op_mask,
    input  logic [DW-1:0]       op_value,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_gnt,
    input  logic                mem_rvalid,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                mem_err,
    output logic                done,
    output logic                error
);

    logic [METHOD_W-1:0] method_q;
    logic [DW-1:0]       mask_q;
    logic [DW-1:0]       value_q;
    logic [DW-1:0]       xf_word;
    rmw_state_e          seq_state;

    rmw_xform #(.DW(DW)) u_xform (
        .method    (method_q),
        .rd_word   (mem_rdata),
        .mask_word (mask_q),
        .val_word  (value_q),
        .new_word  (xf_word)
    );

    rmw_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_method  (op_method),
        .op_addr    (op_addr),
        .op_mask    (op_mask),
        .op_value   (op_value),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_err    (mem_err),
        .xf_word    (xf_word),
        .method_q   (method_q),
        .mask_q     (mask_q),
        .value_q    (value_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .done       (done),
        .error      (error),
        .state      (seq_state)
    );

endmodule

// File: rtl/rmw_op_unit_chk.sv
module rmw_op_unit_chk
    import rmw_pkg::*;
#(
    parameter int AW = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [METHOD_W-1:0] op_method,
    input logic                mem_req,
    input logic                mem_we,
    input logic [AW-1:0]       mem_addr,
    input logic                mem_gnt,
    input logic                mem_rvalid,
    input logic                mem_err,
    input logic                done,
    input logic                error,
    input rmw_state_e          state
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R8

    AST_WRITE_AFTER_GOOD_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_rvalid && !mem_err)); // R9

    AST_RSVD_SHORTCUT: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && op_method > 4'd10) |=> (done && error && !mem_req)); // R7

    AST_RD_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT_RDATA && mem_rvalid && mem_err) |=> (done && error && !mem_req)); // R9

    AST_WR_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state == S_WRITE && mem_gnt && mem_err) |=> (done && error)); // R10

    AST_DONE_NO_REQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        done |=> !mem_req); // R11

endmodule

bind rmw_op_unit rmw_op_unit_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_method  (op_method),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_err    (mem_err),
    .done       (done),
    .error      (error),
    .state      (seq_state)
);

// File: tb/rmw_op_unit_bench.sv
module rmw_op_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    op_method = '0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_mask = '0;
    logic [DW-1:0] op_value = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_err = 1'b0;
    logic          done, error;

    int tests = 0;
    int failed = 0;

    logic [DW-1:0] mem [0:15];
    logic inj_rd_err = 1'b0;
    logic inj_wr_err = 1'b0;
    int   wr_count = 0;
    int   req_cycles = 0;
    int   gcnt = 0;
    int   rcnt = 0;
    logic rd_pend = 1'b0;
    int   rd_idx = 0;

    rmw_op_unit #(.DW(DW), .AW(AW)) u_rmw_op_unit (
        .clk(clk), .rst(rst), .start(start), .op_method(op_method),
        .op_addr(op_addr), .op_mask(op_mask), .op_value(op_value),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .done(done), .error(error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: responds on the falling edge
    always @(negedge clk) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        mem_err    = 1'b0;
        if (rst) begin
            gcnt    = 0;
            rd_pend = 1'b0;
        end else begin
            if (rd_pend) begin
                if (rcnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[rd_idx];
                    mem_err    = inj_rd_err;
                    rd_pend    = 1'b0;
                end else begin
                    rcnt--;
                end
            end
            if (mem_req) begin
                req_cycles++;
                if (gcnt == 0) begin
                    mem_gnt = 1'b1;
                    gcnt = int'($urandom_range(0, 3));
                    if (mem_we) begin
                        wr_count++;
                        mem_err = inj_wr_err;
                        if (!inj_wr_err) mem[mem_addr[3:0]] = mem_wdata;
                    end else begin
                        rd_pend = 1'b1;
                        rd_idx  = int'(mem_addr[3:0]);
                        rcnt    = int'($urandom_range(0, 3));
                    end
                end else begin
                    gcnt--;
                end
            end
        end
    end

    function automatic logic [DW-1:0] model(input logic [3:0] m, input logic [DW-1:0] r,
                                            input logic [DW-1:0] k, input logic [DW-1:0] v);
        case (m)
            4'd0:  return (r & ~k) | v;
            4'd1:  return r + 1;
            4'd2:  return r - 1;
            4'd3:  return {1'b0, r[DW-1:1]};
            4'd4:  return {r[DW-2:0], 1'b0};
            4'd5:  return {r[0], r[DW-1:1]};
            4'd6:  return {r[DW-2:0], r[DW-1]};
            4'd7:  return ~r;
            4'd8:  return r ^ k;
            4'd9:  return r | k;
            4'd10: return r & k;
            default: return r;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7, 4'd8, 4'd9, 4'd10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // mode: 0 plain, 1 start raised in the done cycle, 2 start held while busy
    task automatic run_op(input logic [3:0] m, input int idx, input logic [DW-1:0] init,
                          input logic [DW-1:0] k, input logic [DW-1:0] v,
                          input logic rde, input logic wre, input int mode);
        logic [DW-1:0] exp_word;
        logic exp_err;
        int exp_wr, wc0, rq0, lat;
        string tag;
        mem[idx] = init;
        exp_err  = rde || wre || (m > 4'd10);
        exp_wr   = (m > 4'd10 || rde) ? 0 : 1;
        exp_word = (exp_err) ? init : model(m, init, k, v);
        if (m > 4'd10) tag = "R7";
        else if (rde) tag = "R9";
        else if (wre) tag = "R10";
        else tag = req_of(m);
        @(negedge clk);
        wc0 = wr_count;
        rq0 = req_cycles;
        inj_rd_err = rde;
        inj_wr_err = wre;
        op_method = m;
        op_addr   = AW'(idx);
        op_mask   = k;
        op_value  = v;
        start     = 1'b1;
        @(negedge clk);
        if (mode != 2) start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(done, {tag, " done seen"}, 32'(done), 32'd1);
        check(error == exp_err, {tag, " error flag"}, 32'(error), 32'(exp_err));
        if (m > 4'd10) begin
            check(lat == 0, "R7 done latency", 32'(lat), 32'd0);
        end
        if (mode == 1) begin
            op_method = 4'd7;
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check(!done, "R8 done single cycle", 32'(done), 32'd0);
        if (mode != 0) begin
            repeat (8) @(negedge clk);
            check(!done && !mem_req, "R11 ignored start quiet", 32'(done || mem_req), 32'd0);
        end
        check(mem[idx] == exp_word, {tag, " memory word"}, mem[idx], exp_word);
        check(wr_count - wc0 == exp_wr, {tag, " write count"}, 32'(wr_count - wc0), 32'(exp_wr));
        if (m > 4'd10) begin
            check(req_cycles == rq0, "R7 no request", 32'(req_cycles - rq0), 32'd0);
        end
        inj_rd_err = 1'b0;
        inj_wr_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog expired act=hung exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !error && !mem_req, "R1 reset state", {29'd0, done, error, mem_req}, 32'd0);

        run_op(4'd0, 1, 32'hF0F0_1234, 32'h0000_FFFF, 32'h0000_00AB, 0, 0, 0);
        run_op(4'd1, 2, 32'hFFFF_FFFF, '0, '0, 0, 0, 0);
        run_op(4'd2, 3, 32'h0000_0000, '0, '0, 0, 0, 0);
        run_op(4'd3, 4, 32'h8000_0001, '0, '0, 0, 0, 0);
        run_op(4'd4, 5, 32'h8000_0001, '0, '0, 0, 0, 0);
        run_op(4'd5, 6, 32'h0000_0001, '0, '0, 0, 0, 0);
        run_op(4'd6, 7, 32'h8000_0000, '0, '0, 0, 0, 0);
        run_op(4'd7, 8, 32'h1234_5678, '0, '0, 0, 0, 0);
        run_op(4'd8, 9, 32'hAAAA_5555, 32'hFF00_FF00, '0, 0, 0, 0);
        run_op(4'd9, 10, 32'h0101_0000, 32'h0000_1010, '0, 0, 0, 0);
        run_op(4'd10, 11, 32'hDEAD_BEEF, 32'h0F0F_0F0F, '0, 0, 0, 0);
        run_op(4'd11, 12, 32'h5555_5555, '0, '0, 0, 0, 0);
        run_op(4'd15, 12, 32'h5555_5555, '0, '0, 0, 0, 0);
        run_op(4'd1, 13, 32'h0000_0010, '0, '0, 1, 0, 0);   // R9 read error
        run_op(4'd1, 13, 32'h0000_0010, '0, '0, 0, 1, 0);   // R10 write error
        run_op(4'd1, 14, 32'h0000_0041, '0, '0, 0, 0, 1);   // R11 start in done cycle
        run_op(4'd1, 15, 32'h0000_0070, '0, '0, 0, 0, 2);   // R11 start held while busy

        for (int n = 0; n < 150; n++) begin
            logic [3:0] rm;
            logic re, we;
            rm = 4'($urandom_range(0, 15));
            re = ($urandom_range(0, 7) == 0);
            we = ($urandom_range(0, 7) == 0);
            run_op(rm, int'($urandom_range(0, 15)), $urandom(), $urandom(), $urandom(), re, we, 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule